// File: doc/BRIEF.md
# HDSL Frame Sync Tracker

This block follows frame alignment on a received bit-serial stream that is organised in quats (pairs of bits). One bit arrives on each clock where the bit enable is high. Once per frame it compares the 14-bit word at the expected sync position with a programmed pattern. The result drives a three-level tracker with these levels: locked, a run of errored frames, and lost.

While locked, only the expected position is checked. After a sync error, the tracker also accepts the pattern at nearby positions, at offsets counted in whole quats. The number of bits that agree with the pattern at the expected position sets the search range for the next frame. If the agreement reaches the programmed threshold, the search stays at one quat on each side. If it falls short, the search grows by one quat on each side for every further errored frame, up to a parameter limit. Only an exact pattern match inside the current range restores lock, and lock moves the frame timing onto the offset where the match was found. Each missed frame counts up. When the count reaches the programmed loss criterion, the tracker declares sync lost and starts a bit-by-bit hunt. The hunt returns to lock only after the programmed number of exact matches, each one frame apart.

The threshold, loss and reach values are plain inputs. They are read only at the bit where a frame decision is made.

Top module: `fsync_tracker`

## Requirements
- R1: After reset, `sync_state` reads lost and `err_cnt`, `search_q` and `frame_stb` are zero. The state encoding is 2'b00 lost, 2'b01 errored, 2'b10 locked, and 2'b11 never appears.
- R2: A clock with `bit_en` low accepts no bit. State, count and search range hold, `frame_stb` stays low, and the frame timing does not advance.
- R3: While locked, an exact match at the expected position keeps lock. Any mismatch moves to errored with `err_cnt` = 1 and `search_q` = 1 (positions -1, 0 and +1 quat), unless the loss criterion is 1.
- R4: On each further errored frame without sync, `search_q` returns to 1 if the agreement count at the expected position is at or above `match_thr`. Otherwise it grows by 1, saturating at MAX_Q.
- R5: While errored, only an exact 14-bit match at an offset within ±`search_q` quats restores lock, and it clears `err_cnt` to 0. A word with even one bit wrong, or an exact word outside the range, does not restore lock.
- R6: When lock is restored at an offset of k quats, the next frame is expected 2·k bits away from the old timing, and later frames keep that new timing.
- R7: Each errored frame without sync adds 1 to `err_cnt`. When the count of missed frames reaches `loss_cnt`, the state becomes lost and `err_cnt` returns to 0. A `loss_cnt` of 0 acts as 1.
- R8: While lost, the pattern is searched on every accepted bit. After `reach_cnt` exact matches, each one frame after the previous, the state becomes locked. A mismatch at the qualifying position restarts the hunt. A `reach_cnt` of 0 or 1 locks on the first match.
- R9: `frame_stb` pulses high for one clock after each frame decision bit taken while locked or errored, and never on two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies `bit_in` on this clock |
| bit_in | input | 1 | Received serial bit |
| sync_pat | input | SYNC_W | Programmed sync pattern, MSB received first |
| match_thr | input | $clog2(SYNC_W+1) | Agreement threshold that keeps the search range at ±1 quat |
| reach_cnt | input | CNT_W | Exact matches needed to leave the lost state |
| loss_cnt | input | CNT_W | Missed frames that lead to the lost state |
| sync_state | output | 2 | Tracker level (encoding in R1) |
| err_cnt | output | CNT_W | Missed-frame count while errored |
| search_q | output | $clog2(MAX_Q+1) | Current search half-range in quats |
| frame_stb | output | 1 | One-clock pulse after a frame decision |

## Verification
The bench builds the block with a 40-bit frame and MAX_Q = 4, so the compact frames allow many dozens of frame decisions and several complete loss and reacquire cycles in a short run. With this limit, the range can grow over three frames and still leave room to show that an exact word just outside the range is refused. The loss and reach inputs are changed during the run, through 6, 1 and 0 and through 2 and 1, so that the shortest paths into and out of the lost state are exercised next to the default ones.

// File: rtl/fsync_pkg.sv
// Shared types for the frame sync tracker.
package fsync_pkg;
    typedef enum logic [1:0] {
        ST_OOS  = 2'b00,
        ST_ERR  = 2'b01,
        ST_LOCK = 2'b10
    } fsync_st_e;
endpackage

// File: rtl/fsync_timer.sv
// Frame timer: counts accepted bits down to the next frame decision bit.
// Assumes load is asserted only together with en. A load value above
// FRAME_BITS-1 stretches the current frame, which is how a late offset
// moves the timing.
module fsync_timer #(
    parameter int FRAME_BITS = 4704,
    parameter int MAX_Q      = 6,
    localparam int TW        = $clog2(FRAME_BITS + 2 * MAX_Q)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          eval
);
    logic [TW-1:0] left_q;

    // Down-counter that reloads after each decision bit or takes a realignment value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= TW'(FRAME_BITS - 1);
        end else if (en) begin
            if (load)              left_q <= load_val;
            else if (left_q == '0) left_q <= TW'(FRAME_BITS - 1);
            else                   left_q <= left_q - TW'(1);
        end
    end

    assign eval = en && (left_q == '0);
endmodule

// File: rtl/fsync_corr.sv
// Correlator: keeps the recent bits and compares the pattern at every
// candidate offset in parallel. Offset index i stands for (i - MAX_Q)
// quats; the centre word ends 2*MAX_Q bits before the newest bit, so
// every candidate is complete when the centre one is judged. Outputs are
// combinational on the bit being accepted.
module fsync_corr #(
    parameter int SYNC_W = 14,
    parameter int MAX_Q  = 6,
    localparam int NOFF  = 2 * MAX_Q + 1,
    localparam int MW    = $clog2(SYNC_W + 1),
    localparam int L     = SYNC_W + 4 * MAX_Q
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              din,
    input  logic [SYNC_W-1:0] pat,
    output logic [NOFF-1:0]   exact,
    output logic [MW-1:0]     ctr_match
);
    logic [L-2:0] sr_q;
    logic [L-1:0] sr_n;

    assign sr_n = {sr_q, din};

    // History register of accepted bits, newest at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)  sr_q <= '0;
        else if (en) sr_q <= sr_n[L-2:0];
    end

    // One exact comparator per candidate offset.
    for (genvar i = 0; i < NOFF; i++) begin : g_off
        assign exact[i] = (sr_n[2 * (2 * MAX_Q - i) +: SYNC_W] == pat);
    end

    // Agreement count at the expected position only.
    always_comb begin
        logic [SYNC_W-1:0] agree;
        agree     = ~(sr_n[2 * MAX_Q +: SYNC_W] ^ pat);
        ctr_match = '0;
        for (int k = 0; k < SYNC_W; k++) ctr_match = ctr_match + MW'(agree[k]);
    end
endmodule

// File: rtl/fsync_ctrl.sv
// Tracker control: locked / errored / lost levels, missed-frame count,
// search range, hunt qualification and realignment of the frame timer.
// Assumes exact/ctr_match describe the bit accepted in the same clock.
module fsync_ctrl
    import fsync_pkg::*;
#(
    parameter int SYNC_W     = 14,
    parameter int FRAME_BITS = 4704,
    parameter int MAX_Q      = 6,
    parameter int CNT_W      = 4,
    localparam int NOFF      = 2 * MAX_Q + 1,
    localparam int MW        = $clog2(SYNC_W + 1),
    localparam int QW        = $clog2(MAX_Q + 1),
    localparam int TW        = $clog2(FRAME_BITS + 2 * MAX_Q)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             eval,
    input  logic [NOFF-1:0]  exact,
    input  logic [MW-1:0]    ctr_match,
    input  logic [MW-1:0]    thr,
    input  logic [CNT_W-1:0] reach,
    input  logic [CNT_W-1:0] loss,
    output fsync_st_e        st_o,
    output logic [CNT_W-1:0] err_o,
    output logic [QW-1:0]    win_o,
    output logic             tmr_ld,
    output logic [TW-1:0]    tmr_val,
    output logic             stb_o
);
    fsync_st_e        st_q, st_n;
    logic [CNT_W-1:0] err_q, err_n, hunt_q, hunt_n, loss_e, reach_e;
    logic [CNT_W:0]   err_inc, hunt_inc;
    logic [QW-1:0]    win_q, win_n;
    logic             stb_q, stb_n, hit;
    int               lim, hit_off;

    assign loss_e   = (loss == '0)  ? CNT_W'(1) : loss;
    assign reach_e  = (reach == '0) ? CNT_W'(1) : reach;
    assign err_inc  = {1'b0, err_q} + (CNT_W+1)'(1);
    assign hunt_inc = {1'b0, hunt_q} + (CNT_W+1)'(1);

    // Nearest exact candidate inside the current range, negative side first.
    always_comb begin
        lim     = (st_q == ST_ERR) ? int'(win_q) : 0;
        hit     = 1'b0;
        hit_off = 0;
        for (int d = 0; d <= MAX_Q; d++) begin
            if (!hit && d <= lim) begin
                if (exact[MAX_Q - d]) begin
                    hit = 1'b1; hit_off = -d;
                end else if (exact[MAX_Q + d]) begin
                    hit = 1'b1; hit_off = d;
                end
            end
        end
        tmr_val = TW'(FRAME_BITS - 1 + 2 * hit_off);
    end

    // Next-state decision taken on each accepted bit.
    always_comb begin
        st_n = st_q; err_n = err_q; win_n = win_q; hunt_n = hunt_q;
        tmr_ld = 1'b0; stb_n = 1'b0;
        if (en) begin
            unique case (st_q)
                ST_LOCK: if (eval) begin
                    stb_n = 1'b1;
                    if (hit) tmr_ld = 1'b1;
                    else if (loss_e == CNT_W'(1)) begin
                        st_n = ST_OOS; err_n = '0; win_n = '0; hunt_n = '0;
                    end else begin
                        st_n = ST_ERR; err_n = CNT_W'(1); win_n = QW'(1);
                    end
                end
                ST_ERR: if (eval) begin
                    stb_n = 1'b1;
                    if (hit) begin
                        st_n = ST_LOCK; err_n = '0; win_n = '0; tmr_ld = 1'b1;
                    end else if (err_inc >= {1'b0, loss_e}) begin
                        st_n = ST_OOS; err_n = '0; win_n = '0; hunt_n = '0;
                    end else begin
                        err_n = err_inc[CNT_W-1:0];
                        if (ctr_match >= thr)              win_n = QW'(1);
                        else if (win_q != QW'(MAX_Q))      win_n = win_q + QW'(1);
                    end
                end
                default: if (hunt_q == '0) begin
                    if (hit) begin
                        tmr_ld = 1'b1;
                        if (reach_e == CNT_W'(1)) st_n = ST_LOCK;
                        else                      hunt_n = CNT_W'(1);
                    end
                end else if (eval) begin
                    if (hit) begin
                        tmr_ld = 1'b1;
                        if (hunt_inc >= {1'b0, reach_e}) begin
                            st_n = ST_LOCK; hunt_n = '0;
                        end else begin
                            hunt_n = hunt_inc[CNT_W-1:0];
                        end
                    end else begin
                        hunt_n = '0;
                    end
                end
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OOS; err_q <= '0; win_q <= '0; hunt_q <= '0; stb_q <= 1'b0;
        end else begin
            st_q <= st_n; err_q <= err_n; win_q <= win_n; hunt_q <= hunt_n; stb_q <= stb_n;
        end
    end

    assign st_o  = st_q;
    assign err_o = err_q;
    assign win_o = win_q;
    assign stb_o = stb_q;
endmodule

// File: rtl/fsync_tracker.sv
// Top of the frame sync tracker: correlator, frame timer and control.
// Assumes one bit per clock at most, qualified by bit_en.
module fsync_tracker
    import fsync_pkg::*;
#(
    parameter int SYNC_W     = 14,
    parameter int FRAME_BITS = 4704,
    parameter int MAX_Q      = 6,
    parameter int CNT_W      = 4,
    localparam int NOFF      = 2 * MAX_Q + 1,
    localparam int MW        = $clog2(SYNC_W + 1),
    localparam int QW        = $clog2(MAX_Q + 1),
    localparam int TW        = $clog2(FRAME_BITS + 2 * MAX_Q)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic [SYNC_W-1:0] sync_pat,
    input  logic [MW-1:0]     match_thr,
    input  logic [CNT_W-1:0]  reach_cnt,
    input  logic [CNT_W-1:0]  loss_cnt,
    output logic [1:0]        sync_state,
    output logic [CNT_W-1:0]  err_cnt,
    output logic [QW-1:0]     search_q,
    output logic              frame_stb
);
    logic [NOFF-1:0] exact;
    logic [MW-1:0]   ctr_match;
    logic            eval, tmr_ld;
    logic [TW-1:0]   tmr_val;
    fsync_st_e       st;

    fsync_corr #(.SYNC_W(SYNC_W), .MAX_Q(MAX_Q)) i_corr (
        .clk(clk), .rst_n(rst_n), .en(bit_en), .din(bit_in), .pat(sync_pat),
        .exact(exact), .ctr_match(ctr_match)
    );

    fsync_timer #(.FRAME_BITS(FRAME_BITS), .MAX_Q(MAX_Q)) i_timer (
        .clk(clk), .rst_n(rst_n), .en(bit_en), .load(tmr_ld), .load_val(tmr_val),
        .eval(eval)
    );

    fsync_ctrl #(.SYNC_W(SYNC_W), .FRAME_BITS(FRAME_BITS), .MAX_Q(MAX_Q), .CNT_W(CNT_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .en(bit_en), .eval(eval), .exact(exact),
        .ctr_match(ctr_match), .thr(match_thr), .reach(reach_cnt), .loss(loss_cnt),
        .st_o(st), .err_o(err_cnt), .win_o(search_q), .tmr_ld(tmr_ld),
        .tmr_val(tmr_val), .stb_o(frame_stb)
    );

    assign sync_state = st;
endmodule

// File: rtl/fsync_tracker_chk.sv
// Property checker for fsync_tracker, attached by bind below.
module fsync_tracker_chk
    import fsync_pkg::*;
#(
    parameter int SYNC_W     = 14,
    parameter int FRAME_BITS = 4704,
    parameter int MAX_Q      = 6,
    parameter int CNT_W      = 4,
    localparam int MW        = $clog2(SYNC_W + 1),
    localparam int QW        = $clog2(MAX_Q + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              bit_in,
    input logic [SYNC_W-1:0] sync_pat,
    input logic [MW-1:0]     match_thr,
    input logic [CNT_W-1:0]  reach_cnt,
    input logic [CNT_W-1:0]  loss_cnt,
    input logic [1:0]        sync_state,
    input logic [CNT_W-1:0]  err_cnt,
    input logic [QW-1:0]     search_q,
    input logic              frame_stb
);
    assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sync_state != 2'b11);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(sync_state) && $stable(err_cnt) && $stable(search_q) && !frame_stb));

    assert_enter_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_state == ST_ERR && $past(sync_state) == ST_LOCK)
        |-> (err_cnt == CNT_W'(1) && search_q == QW'(1)));

    assert_range_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_state == ST_ERR) |-> (search_q >= QW'(1) && search_q <= QW'(MAX_Q)));

    assert_restore_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_state == ST_LOCK && $past(sync_state) == ST_ERR) |-> (err_cnt == '0));

    assert_count_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_state != ST_ERR) |-> (err_cnt == '0 && search_q == '0));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_state == ST_ERR && $past(sync_state) == ST_ERR)
        |-> (err_cnt == $past(err_cnt) || err_cnt == $past(err_cnt) + CNT_W'(1)));

    assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);
endmodule

bind fsync_tracker fsync_tracker_chk #(
    .SYNC_W(SYNC_W), .FRAME_BITS(FRAME_BITS), .MAX_Q(MAX_Q), .CNT_W(CNT_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .sync_pat(sync_pat),
    .match_thr(match_thr), .reach_cnt(reach_cnt), .loss_cnt(loss_cnt),
    .sync_state(sync_state), .err_cnt(err_cnt), .search_q(search_q), .frame_stb(frame_stb)
);

// File: tb/test_fsync_tracker.sv
`timescale 1ns/1ps
module test_fsync_tracker;
    localparam int SW = 14;
    localparam int FB = 40;
    localparam int MQ = 4;
    localparam int CW = 4;
    localparam int MW = $clog2(SW + 1);
    localparam int QW = $clog2(MQ + 1);
    localparam int L  = SW + 4 * MQ;
    localparam logic [SW-1:0] PAT = 14'b10110101101011;

    logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
    logic [MW-1:0] match_thr = MW'(12);
    logic [CW-1:0] reach_cnt = CW'(2), loss_cnt = CW'(6);
    logic [1:0]    sync_state;
    logic [CW-1:0] err_cnt;
    logic [QW-1:0] search_q;
    logic          frame_stb;

    always #4 clk = ~clk;

    fsync_tracker #(.SYNC_W(SW), .FRAME_BITS(FB), .MAX_Q(MQ), .CNT_W(CW)) i_fsync_tracker (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in), .sync_pat(PAT),
        .match_thr(match_thr), .reach_cnt(reach_cnt), .loss_cnt(loss_cnt),
        .sync_state(sync_state), .err_cnt(err_cnt), .search_q(search_q), .frame_stb(frame_stb)
    );

    int total = 0, bad = 0, gap_cnt = 0, stb_seen = 0;
    bit done = 0;

    // reference model state: 0 lost, 1 errored, 2 locked
    bit hist[$];
    int m_st = 0, m_err = 0, m_win = 0, m_hunt = 0, m_left = FB - 1;
    bit m_stb = 0;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int mcount(input int o);
        int d = 2 * (MQ - o);
        int n = 0;
        for (int k = 0; k < SW; k++)
            if (hist[hist.size() - 1 - d - k] == PAT[k]) n++;
        return n;
    endfunction

    task automatic model_step(input bit e, input bit d);
        bit ev, ld, hit, stb;
        int off, lim, le, re;
        if (!e) begin m_stb = 0; return; end
        hist.push_back(d);
        void'(hist.pop_front());
        le = (loss_cnt == 0) ? 1 : int'(loss_cnt);
        re = (reach_cnt == 0) ? 1 : int'(reach_cnt);
        ev = (m_left == 0); ld = 0; stb = 0; hit = 0; off = 0;
        lim = (m_st == 1) ? m_win : 0;
        for (int dd = 0; dd <= lim; dd++) begin
            if (!hit) begin
                if (mcount(-dd) == SW) begin hit = 1; off = -dd; end
                else if (mcount(dd) == SW) begin hit = 1; off = dd; end
            end
        end
        if (m_st == 2) begin
            if (ev) begin
                stb = 1;
                if (hit) ld = 1;
                else if (le <= 1) begin m_st = 0; m_err = 0; m_win = 0; m_hunt = 0; end
                else begin m_st = 1; m_err = 1; m_win = 1; end
            end
        end else if (m_st == 1) begin
            if (ev) begin
                stb = 1;
                if (hit) begin m_st = 2; m_err = 0; m_win = 0; ld = 1; end
                else if (m_err + 1 >= le) begin m_st = 0; m_err = 0; m_win = 0; m_hunt = 0; end
                else begin
                    m_err++;
                    if (mcount(0) >= int'(match_thr)) m_win = 1;
                    else if (m_win < MQ) m_win++;
                end
            end
        end else if (m_hunt == 0) begin
            if (hit) begin
                ld = 1;
                if (re <= 1) m_st = 2; else m_hunt = 1;
            end
        end else if (ev) begin
            if (hit) begin
                ld = 1;
                if (m_hunt + 1 >= re) begin m_st = 2; m_hunt = 0; end
                else m_hunt++;
            end else m_hunt = 0;
        end
        if (ld) m_left = FB - 1 + 2 * off;
        else if (m_left == 0) m_left = FB - 1;
        else m_left--;
        m_stb = stb;
    endtask

    // one clock: drive away from the edge, step the model, compare after the edge
    task automatic tick(input bit e, input bit d);
        @(negedge clk);
        bit_en = e; bit_in = d;
        model_step(e, d);
        @(posedge clk);
        #1;
        check(int'(sync_state) == m_st, "R3", "state vs model", int'(sync_state), m_st);
        check(int'(err_cnt) == m_err, "R7", "err_cnt vs model", int'(err_cnt), m_err);
        check(int'(search_q) == m_win, "R4", "search_q vs model", int'(search_q), m_win);
        check(frame_stb == m_stb, "R9", "frame_stb vs model", int'(frame_stb), int'(m_stb));
        if (frame_stb) stb_seen++;
    endtask

    task automatic send_bit(input bit b);
        gap_cnt++;
        if (gap_cnt % 11 == 0) tick(1'b0, 1'b1);
        tick(1'b1, b);
    endtask

    // frame: 2*pre extra zero bits, sync word with first nerr bits flipped, zero payload
    task automatic send_frame(input int nerr, input int pre);
        for (int i = 0; i < 2 * pre; i++) send_bit(1'b0);
        for (int i = 0; i < SW; i++) send_bit(PAT[SW-1-i] ^ (i < nerr));
        for (int i = 0; i < FB - SW; i++) send_bit(1'b0);
    endtask

    task automatic expect_out(input int st, input int ec, input int w, input string tag);
        check(int'(sync_state) == st, tag, "sync_state", int'(sync_state), st);
        check(int'(err_cnt) == ec, tag, "err_cnt", int'(err_cnt), ec);
        check(int'(search_q) == w, tag, "search_q", int'(search_q), w);
    endtask

    initial begin
        repeat (L) hist.push_back(1'b0);
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        expect_out(0, 0, 0, "R1");
        check(frame_stb == 1'b0, "R1", "frame_stb", int'(frame_stb), 0);

        // R8: two exact matches one frame apart are needed with reach 2
        send_frame(0, 0); expect_out(0, 0, 0, "R8");
        send_frame(0, 0); expect_out(2, 0, 0, "R8");
        stb_seen = 0;
        send_frame(0, 0); send_frame(0, 0);
        check(stb_seen == 2, "R9", "strobes in two locked frames", stb_seen, 2);

        // R2: idle clocks with toggling data change nothing
        stb_seen = 0;
        for (int i = 0; i < 20; i++) tick(1'b0, i[0]);
        expect_out(2, 0, 0, "R2");
        check(stb_seen == 0, "R2", "strobes while idle", stb_seen, 0);
        send_frame(0, 0); expect_out(2, 0, 0, "R2");

        // R3, R5: one-bit error then a good word
        send_frame(1, 0); expect_out(1, 1, 1, "R3");
        send_frame(0, 0); expect_out(2, 0, 0, "R5");

        // R4 hold at threshold, R5 partial word refused, R6 realign by +1 quat
        send_frame(1, 0); expect_out(1, 1, 1, "R3");
        send_frame(1, 0); expect_out(1, 2, 1, "R4");
        send_frame(0, 1); expect_out(2, 0, 0, "R6");
        send_frame(0, 0); expect_out(2, 0, 0, "R6");

        // R4 widening below threshold, then restore at +3 quats
        send_frame(5, 0); expect_out(1, 1, 1, "R4");
        send_frame(5, 0); expect_out(1, 2, 2, "R4");
        send_frame(5, 0); expect_out(1, 3, 3, "R4");
        send_frame(0, 3); expect_out(2, 0, 0, "R6");
        send_frame(0, 0); expect_out(2, 0, 0, "R6");

        // R5: exact word outside the range is refused, accepted once range grows
        send_frame(1, 0); expect_out(1, 1, 1, "R5");
        send_frame(0, 2); expect_out(1, 2, 2, "R5");
        send_frame(0, 0); expect_out(2, 0, 0, "R5");

        // R7: six missed frames with loss 6
        for (int n = 1; n <= 5; n++) begin
            send_frame(5, 0); expect_out(1, n, (n < MQ) ? n : MQ, "R7");
        end
        send_frame(5, 0); expect_out(0, 0, 0, "R7");
        send_frame(0, 0); send_frame(0, 0); expect_out(2, 0, 0, "R8");

        // R7 loss 1, R8 qualification restart on a mismatch
        loss_cnt = CW'(1);
        send_frame(1, 0); expect_out(0, 0, 0, "R7");
        send_frame(0, 0); send_frame(1, 0);
        send_frame(0, 0); expect_out(0, 0, 0, "R8");
        send_frame(0, 0); expect_out(2, 0, 0, "R8");

        // R7 loss 0 acts as 1, R8 reach 1 locks on the first match
        loss_cnt = CW'(0); reach_cnt = CW'(1);
        send_frame(1, 0); expect_out(0, 0, 0, "R7");
        send_frame(0, 0); expect_out(2, 0, 0, "R8");
        send_frame(0, 0); expect_out(2, 0, 0, "R3");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule